// File: doc/BRIEF.md
# Dual Memory Self-Test Controller

This block runs a built-in self-test over two on-chip RAMs that sit next to a filter channel: a coefficient store (256 words by default) and the filter's sample store (128 words by default). Software may only launch the test while the channel sleeps. A launch is a control write with bit 0 set. From then on the controller owns the write and read ports of both RAMs. It walks a six-element march pattern over each RAM, and both RAMs are tested in parallel. At the end it posts one fail flag per RAM in a 3-bit status word that software polls.

Each RAM is a simple dual-port synchronous memory: one write port and one read port, with read-first behaviour when both ports hit the same address in the same cycle. Because of this, every read-then-write step of the march fits in a single cycle. A RAM of N words therefore needs 6N cycles, plus one cycle to check the last read. Outside a test, the functional write and read ports pass straight through to the RAMs. During a test, functional writes are dropped and functional reads return zero. RAM contents are undefined after a test.

Top module: `mem_selftest_ctrl`

## Requirements
- R1: After reset the status word is 0. A cycle in which `ctrl_wr_i` and `ctrl_bit0_i` are both 1 while `sleep_i` is 1 starts a test. From the next cycle `status_o[0]` (running) reads 1 and both fail flags read 0.
- R2: A start request made while `sleep_i` is 0 is ignored, and so is one made while a test is already running. The status word and the RAM contents are left untouched, and a running test ends at its normal time.
- R3: `status_o[0]` stays 1 for exactly 6*max(coefficient depth, sample depth)+1 cycles after the start cycle. That is 1537 cycles with the defaults, which is under the 1600-cycle budget. After this the status word is final.
- R4: `status_o[1]` set after completion means the coefficient RAM returned at least one wrong read.
- R5: `status_o[2]` set after completion means the sample RAM returned at least one wrong read.
- R6: Each RAM sees these six elements, with background 0 = all bits 0 and 1 = all bits 1:
  - up: write 0
  - up: read 0 / write 1
  - up: read 1 / write 0
  - down: read 0 / write 1
  - down: read 1 / write 0
  - up: read 0

  Any single stuck-at bit therefore sets that RAM's fail flag, and a fault-free RAM leaves it clear.
- R7: A fail flag stays set from the first mismatch until the next accepted start, which clears it.
- R8: While a test runs, functional reads return 0 and functional writes never reach a RAM. The RAM write data is only ever the all-0 or all-1 background.
- R9: When no test runs, the functional ports pass through to the RAMs: a write lands, and a read returns the data one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Channel is in sleep; a test start is only accepted when 1 |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_bit0_i | input | 1 | Bit 0 of the control write data (start) |
| status_o | output | 3 | {sample fail, coefficient fail, running} |
| fc_we_i | input | 1 | Functional coefficient write enable |
| fc_waddr_i | input | 8 | Functional coefficient write address |
| fc_wdata_i | input | 18 | Functional coefficient write data |
| fc_raddr_i | input | 8 | Functional coefficient read address |
| fc_rdata_o | output | 18 | Functional coefficient read data (0 during test) |
| fs_we_i | input | 1 | Functional sample write enable |
| fs_waddr_i | input | 7 | Functional sample write address |
| fs_wdata_i | input | 16 | Functional sample write data |
| fs_raddr_i | input | 7 | Functional sample read address |
| fs_rdata_o | output | 16 | Functional sample read data (0 during test) |
| cram_we_o | output | 1 | Coefficient RAM write enable |
| cram_waddr_o | output | 8 | Coefficient RAM write address |
| cram_wdata_o | output | 18 | Coefficient RAM write data |
| cram_raddr_o | output | 8 | Coefficient RAM read address |
| cram_rdata_i | input | 18 | Coefficient RAM read data, one cycle after address |
| sram_we_o | output | 1 | Sample RAM write enable |
| sram_waddr_o | output | 7 | Sample RAM write address |
| sram_wdata_o | output | 16 | Sample RAM write data |
| sram_raddr_o | output | 7 | Sample RAM read address |
| sram_rdata_i | input | 16 | Sample RAM read data, one cycle after address |

## Verification
The assertions rely on three assumptions about the RAMs:
- each one returns read data one cycle after the address;
- each one is read-first on a same-address write;
- neither one changes content on its own.

Under these, a fail flag can only come from a real fault. The bench's RAM models follow exactly this timing. Faults enter only through a stuck-at hook on the read path, with its address, bit and level drawn from `$urandom` under a fixed seed. Control writes are driven a half cycle away from the clock edge, so a start request is never ambiguous with respect to `sleep_i`.

// File: rtl/msc_pkg.sv
package msc_pkg;

    // March elements in the order they are applied
    typedef enum logic [2:0] {
        EL_UP_W0     = 3'd0,
        EL_UP_R0W1   = 3'd1,
        EL_UP_R1W0   = 3'd2,
        EL_DN_R0W1   = 3'd3,
        EL_DN_R1W0   = 3'd4,
        EL_UP_R0     = 3'd5
    } march_el_e;

    localparam int unsigned NUM_ELEMENTS = 6;

    function automatic logic el_reads(march_el_e e);
        return e != EL_UP_W0;
    endfunction

    function automatic logic el_writes(march_el_e e);
        return e != EL_UP_R0;
    endfunction

    function automatic logic el_expect_one(march_el_e e);
        return (e == EL_UP_R1W0) || (e == EL_DN_R1W0);
    endfunction

    function automatic logic el_write_one(march_el_e e);
        return (e == EL_UP_R0W1) || (e == EL_DN_R0W1);
    endfunction

    function automatic logic el_descending(march_el_e e);
        return (e == EL_DN_R0W1) || (e == EL_DN_R1W0);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/msc_march_engine.sv
module msc_march_engine
    import msc_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 18,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] rdata_i,
    output logic          busy_o,
    output logic          fail_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o,
    output logic [AW-1:0] raddr_o
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [DW-1:0] ALL_ONES  = {DW{1'b1}};

    typedef struct packed {
        logic          busy;
        logic          drain;
        march_el_e     elem;
        logic [AW-1:0] addr;
        logic          chk_valid;
        logic          chk_one;
        logic          fail;
    } eng_s;

    eng_s      s_d, s_q;
    logic      mismatch;
    logic      last_addr;
    march_el_e next_el;

    always_comb begin
        s_d       = s_q;
        mismatch  = s_q.chk_valid && (rdata_i != (s_q.chk_one ? ALL_ONES : '0));
        last_addr = el_descending(s_q.elem) ? (s_q.addr == '0) : (s_q.addr == LAST_ADDR);
        next_el   = march_el_e'(s_q.elem + 3'd1);

        s_d.fail      = s_q.fail | mismatch;
        s_d.chk_valid = 1'b0;

        if (start_i && !s_q.busy) begin
            s_d.busy      = 1'b1;
            s_d.drain     = 1'b0;
            s_d.elem      = EL_UP_W0;
            s_d.addr      = '0;
            s_d.chk_one   = 1'b0;
            s_d.fail      = 1'b0;
        end else if (s_q.busy && !s_q.drain) begin
            s_d.chk_valid = el_reads(s_q.elem);
            s_d.chk_one   = el_expect_one(s_q.elem);
            if (last_addr) begin
                if (s_q.elem == EL_UP_R0) begin
                    s_d.drain = 1'b1;
                end else begin
                    s_d.elem = next_el;
                    s_d.addr = el_descending(next_el) ? LAST_ADDR : '0;
                end
            end else if (el_descending(s_q.elem)) begin
                s_d.addr = s_q.addr - 1'b1;
            end else begin
                s_d.addr = s_q.addr + 1'b1;
            end
        end else if (s_q.drain) begin
            s_d.busy  = 1'b0;
            s_d.drain = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = s_q.busy;
    assign fail_o  = s_q.fail;
    assign we_o    = s_q.busy && !s_q.drain && el_writes(s_q.elem);
    assign waddr_o = s_q.addr;
    assign raddr_o = s_q.addr;
    assign wdata_o = el_write_one(s_q.elem) ? ALL_ONES : '0;

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fail && !start_i) |=> s_q.fail);

    // R6
    march_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> ($past(s_q.elem) == EL_UP_R0));

endmodule

// File: rtl/msc_port_mux.sv
module msc_port_mux #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_i,
    input  logic          eng_we_i,
    input  logic [AW-1:0] eng_waddr_i,
    input  logic [DW-1:0] eng_wdata_i,
    input  logic [AW-1:0] eng_raddr_i,
    input  logic          fn_we_i,
    input  logic [AW-1:0] fn_waddr_i,
    input  logic [DW-1:0] fn_wdata_i,
    input  logic [AW-1:0] fn_raddr_i,
    output logic [DW-1:0] fn_rdata_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic [AW-1:0] mem_raddr_o,
    input  logic [DW-1:0] mem_rdata_i
);

    always_comb begin
        if (test_i) begin
            mem_we_o    = eng_we_i;
            mem_waddr_o = eng_waddr_i;
            mem_wdata_o = eng_wdata_i;
            mem_raddr_o = eng_raddr_i;
            fn_rdata_o  = '0;
        end else begin
            mem_we_o    = fn_we_i;
            mem_waddr_o = fn_waddr_i;
            mem_wdata_o = fn_wdata_i;
            mem_raddr_o = fn_raddr_i;
            fn_rdata_o  = mem_rdata_i;
        end
    end

    // R8
    bg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_i && mem_we_o) |-> ((mem_wdata_o == '0) || (mem_wdata_o == {DW{1'b1}})));

endmodule

// File: rtl/msc_ctrl.sv
module msc_ctrl #(
    parameter int unsigned BUDGET = 1600,
    localparam int unsigned CW    = $clog2(BUDGET + 1) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic wr_i,
    input  logic bit0_i,
    input  logic busy_i,
    input  logic coef_fail_i,
    input  logic samp_fail_i,
    output logic start_o
);

    typedef struct packed {
        logic [CW-1:0] run_cnt;
    } ctl_s;

    ctl_s c_d, c_q;

    always_comb begin
        c_d     = c_q;
        start_o = wr_i && bit0_i && sleep_i && !busy_i;
        if (busy_i) c_d.run_cnt = c_q.run_cnt + 1'b1;
        else        c_d.run_cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R1
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (busy_i && !coef_fail_i && !samp_fail_i));

    // R2
    awake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && bit0_i && !sleep_i && !busy_i) |=> !busy_i);

    // R3
    budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (c_q.run_cnt < CW'(BUDGET)));

endmodule

// File: rtl/mem_selftest_ctrl.sv
module mem_selftest_ctrl
    import msc_pkg::*;
#(
    parameter int unsigned COEF_DEPTH = 256,
    parameter int unsigned COEF_W     = 18,
    parameter int unsigned SAMP_DEPTH = 128,
    parameter int unsigned SAMP_W     = 16,
    parameter int unsigned BUDGET     = 1600,
    localparam int unsigned CAW       = $clog2(COEF_DEPTH),
    localparam int unsigned SAW       = $clog2(SAMP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              ctrl_wr_i,
    input  logic              ctrl_bit0_i,
    output logic [2:0]        status_o,
    input  logic              fc_we_i,
    input  logic [CAW-1:0]    fc_waddr_i,
    input  logic [COEF_W-1:0] fc_wdata_i,
    input  logic [CAW-1:0]    fc_raddr_i,
    output logic [COEF_W-1:0] fc_rdata_o,
    input  logic              fs_we_i,
    input  logic [SAW-1:0]    fs_waddr_i,
    input  logic [SAMP_W-1:0] fs_wdata_i,
    input  logic [SAW-1:0]    fs_raddr_i,
    output logic [SAMP_W-1:0] fs_rdata_o,
    output logic              cram_we_o,
    output logic [CAW-1:0]    cram_waddr_o,
    output logic [COEF_W-1:0] cram_wdata_o,
    output logic [CAW-1:0]    cram_raddr_o,
    input  logic [COEF_W-1:0] cram_rdata_i,
    output logic              sram_we_o,
    output logic [SAW-1:0]    sram_waddr_o,
    output logic [SAMP_W-1:0] sram_wdata_o,
    output logic [SAW-1:0]    sram_raddr_o,
    input  logic [SAMP_W-1:0] sram_rdata_i
);

    localparam int unsigned RUN_CYCLES = NUM_ELEMENTS * max_u(COEF_DEPTH, SAMP_DEPTH) + 1;

    logic              start;
    logic              busy;
    logic              c_busy, c_fail, c_we;
    logic [CAW-1:0]    c_waddr, c_raddr;
    logic [COEF_W-1:0] c_wdata;
    logic              s_busy, s_fail, s_we;
    logic [SAW-1:0]    s_waddr, s_raddr;
    logic [SAMP_W-1:0] s_wdata;

    assign busy     = c_busy | s_busy;
    assign status_o = {s_fail, c_fail, busy};

    msc_ctrl #(.BUDGET(BUDGET)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .wr_i       (ctrl_wr_i),
        .bit0_i     (ctrl_bit0_i),
        .busy_i     (busy),
        .coef_fail_i(c_fail),
        .samp_fail_i(s_fail),
        .start_o    (start)
    );

    msc_march_engine #(.DEPTH(COEF_DEPTH), .DW(COEF_W)) u_coef_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .rdata_i(cram_rdata_i),
        .busy_o (c_busy),
        .fail_o (c_fail),
        .we_o   (c_we),
        .waddr_o(c_waddr),
        .wdata_o(c_wdata),
        .raddr_o(c_raddr)
    );

    msc_march_engine #(.DEPTH(SAMP_DEPTH), .DW(SAMP_W)) u_samp_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .rdata_i(sram_rdata_i),
        .busy_o (s_busy),
        .fail_o (s_fail),
        .we_o   (s_we),
        .waddr_o(s_waddr),
        .wdata_o(s_wdata),
        .raddr_o(s_raddr)
    );

    msc_port_mux #(.AW(CAW), .DW(COEF_W)) u_coef_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_i     (busy),
        .eng_we_i   (c_we),
        .eng_waddr_i(c_waddr),
        .eng_wdata_i(c_wdata),
        .eng_raddr_i(c_raddr),
        .fn_we_i    (fc_we_i),
        .fn_waddr_i (fc_waddr_i),
        .fn_wdata_i (fc_wdata_i),
        .fn_raddr_i (fc_raddr_i),
        .fn_rdata_o (fc_rdata_o),
        .mem_we_o   (cram_we_o),
        .mem_waddr_o(cram_waddr_o),
        .mem_wdata_o(cram_wdata_o),
        .mem_raddr_o(cram_raddr_o),
        .mem_rdata_i(cram_rdata_i)
    );

    msc_port_mux #(.AW(SAW), .DW(SAMP_W)) u_samp_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_i     (busy),
        .eng_we_i   (s_we),
        .eng_waddr_i(s_waddr),
        .eng_wdata_i(s_wdata),
        .eng_raddr_i(s_raddr),
        .fn_we_i    (fs_we_i),
        .fn_waddr_i (fs_waddr_i),
        .fn_wdata_i (fs_wdata_i),
        .fn_raddr_i (fs_raddr_i),
        .fn_rdata_o (fs_rdata_o),
        .mem_we_o   (sram_we_o),
        .mem_waddr_o(sram_waddr_o),
        .mem_wdata_o(sram_wdata_o),
        .mem_raddr_o(sram_raddr_o),
        .mem_rdata_i(sram_rdata_i)
    );

    // R8
    no_func_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cram_we_o == c_we) && (sram_we_o == s_we));

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy) && (RUN_CYCLES <= BUDGET));

endmodule

// File: tb/test_mem_selftest_ctrl.sv
module test_mem_selftest_ctrl;

    localparam int CD = 256, CWID = 18, SD = 128, SWID = 16;
    localparam int CAW = 8, SAW = 7;
    localparam int EXP_RUN = 6 * CD + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic sleep_i = 1'b0, ctrl_wr_i = 1'b0, ctrl_bit0_i = 1'b0;
    logic [2:0] status_o;
    logic fc_we_i = 1'b0;
    logic [CAW-1:0] fc_waddr_i = '0, fc_raddr_i = '0;
    logic [CWID-1:0] fc_wdata_i = '0, fc_rdata_o;
    logic fs_we_i = 1'b0;
    logic [SAW-1:0] fs_waddr_i = '0, fs_raddr_i = '0;
    logic [SWID-1:0] fs_wdata_i = '0, fs_rdata_o;
    logic cram_we_o, sram_we_o;
    logic [CAW-1:0] cram_waddr_o, cram_raddr_o;
    logic [SAW-1:0] sram_waddr_o, sram_raddr_o;
    logic [CWID-1:0] cram_wdata_o, cram_rdata_i;
    logic [SWID-1:0] sram_wdata_o, sram_rdata_i;

    mem_selftest_ctrl i_mem_selftest_ctrl (.*);

    // RAM models with stuck-at hooks on the read path
    logic [CWID-1:0] cmem [CD];
    logic [SWID-1:0] smem [SD];
    logic cf_en = 1'b0, sf_en = 1'b0, cf_val = 1'b0, sf_val = 1'b0;
    int unsigned cf_addr = 0, cf_bit = 0, sf_addr = 0, sf_bit = 0;

    function automatic logic [CWID-1:0] cfault(logic [CWID-1:0] v, logic [CAW-1:0] a);
        logic [CWID-1:0] r = v;
        if (cf_en && (int'(a) == cf_addr)) r[cf_bit] = cf_val;
        return r;
    endfunction

    function automatic logic [SWID-1:0] sfault(logic [SWID-1:0] v, logic [SAW-1:0] a);
        logic [SWID-1:0] r = v;
        if (sf_en && (int'(a) == sf_addr)) r[sf_bit] = sf_val;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (cram_we_o) cmem[cram_waddr_o] <= cram_wdata_o;
        cram_rdata_i <= cfault(cmem[cram_raddr_o], cram_raddr_o);
        if (sram_we_o) smem[sram_waddr_o] <= sram_wdata_o;
        sram_rdata_i <= sfault(smem[sram_raddr_o], sram_raddr_o);
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(logic run, logic cbad, logic sbad);
        return {sbad, cbad, run};
    endfunction

    function automatic logic is_bg(logic [31:0] v, int w);
        logic [31:0] ones = (32'd1 << w) - 32'd1;
        return (v == 32'd0) || (v == ones);
    endfunction

    task automatic run_test(input bit poke, input string tag);
        int cyc = 0;
        @(negedge clk); ctrl_wr_i = 1'b1; ctrl_bit0_i = 1'b1;
        @(negedge clk); ctrl_wr_i = 1'b0; ctrl_bit0_i = 1'b0;
        chk({"R1 running/clear ", tag}, 32'(status_o), 32'(exp_status(1'b1, 1'b0, 1'b0)));
        while (status_o[0] && cyc < 4000) begin
            cyc++;
            if (cyc == 50) begin
                chk("R8 coef read blocked", 32'(fc_rdata_o), 32'd0);
                chk("R8 samp read blocked", 32'(fs_rdata_o), 32'd0);
            end
            if (cyc == 61) begin
                chk("R8 coef wdata background", 32'(is_bg(32'(cram_wdata_o), CWID)), 32'd1);
                chk("R8 samp wdata background", 32'(is_bg(32'(sram_wdata_o), SWID)), 32'd1);
                fc_we_i = 1'b0; fs_we_i = 1'b0;
            end
            if (cyc == 60) begin
                fc_we_i = 1'b1; fc_wdata_i = 18'h2A5A5;
                fs_we_i = 1'b1; fs_wdata_i = 16'h5AA5;
            end
            if (poke && cyc == 100) begin ctrl_wr_i = 1'b1; ctrl_bit0_i = 1'b1; end
            else begin ctrl_wr_i = 1'b0; ctrl_bit0_i = 1'b0; end
            @(negedge clk);
        end
        chk({"R3 run length ", tag}, 32'(cyc), 32'(EXP_RUN));
        chk("R3 within budget", 32'(cyc <= 1600), 32'd1);
    endtask

    task automatic fault_run(input logic ce, input logic se, input string tag);
        cf_en = ce; sf_en = se;
        run_test(1'b0, tag);
        chk({"R4/R5 status ", tag}, 32'(status_o), 32'(exp_status(1'b0, ce, se)));
        cf_en = 1'b0; sf_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", 32'(status_o), 32'd0);

        // R9 idle pass-through
        fc_we_i = 1'b1; fc_waddr_i = 8'd5; fc_wdata_i = 18'h1C3A7;
        fs_we_i = 1'b1; fs_waddr_i = 7'd9; fs_wdata_i = 16'hBEEF;
        @(negedge clk);
        fc_we_i = 1'b0; fs_we_i = 1'b0; fc_raddr_i = 8'd5; fs_raddr_i = 7'd9;
        @(negedge clk);
        chk("R9 coef pass-through", 32'(fc_rdata_o), 32'h1C3A7);
        chk("R9 samp pass-through", 32'(fs_rdata_o), 32'hBEEF);

        // R2 start while awake is ignored
        sleep_i = 1'b0;
        ctrl_wr_i = 1'b1; ctrl_bit0_i = 1'b1;
        @(negedge clk);
        ctrl_wr_i = 1'b0; ctrl_bit0_i = 1'b0;
        chk("R2 awake start status", 32'(status_o), 32'd0);
        @(negedge clk);
        chk("R2 coef contents kept", 32'(fc_rdata_o), 32'h1C3A7);
        chk("R2 samp contents kept", 32'(fs_rdata_o), 32'hBEEF);

        // R6 fault-free run, with a start poke mid-test (R2)
        sleep_i = 1'b1;
        run_test(1'b1, "clean+poke");
        chk("R6 clean status", 32'(status_o), 32'd0);

        // R4/R5 directed corners
        cf_addr = 0;      cf_bit = 0;        cf_val = 1'b1;
        fault_run(1'b1, 1'b0, "coef addr0 sa1");
        sf_addr = SD - 1; sf_bit = SWID - 1; sf_val = 1'b0;
        fault_run(1'b0, 1'b1, "samp last sa0");
        cf_addr = CD - 1; cf_bit = CWID - 1; cf_val = 1'b0;
        sf_addr = 0;      sf_bit = 3;        sf_val = 1'b1;
        fault_run(1'b1, 1'b1, "both");

        // R7 sticky then cleared by a new start
        cf_addr = 77; cf_bit = 4; cf_val = 1'b0;
        fault_run(1'b1, 1'b0, "sticky setup");
        repeat (5) @(negedge clk);
        chk("R7 flag held while idle", 32'(status_o), 32'(exp_status(1'b0, 1'b1, 1'b0)));
        run_test(1'b0, "after fail");
        chk("R7 cleared by clean run", 32'(status_o), 32'd0);

        // R6 random stuck-at faults
        for (int i = 0; i < 8; i++) begin
            logic ce, se;
            ce = 1'($urandom_range(1)); se = 1'($urandom_range(1));
            cf_addr = $urandom_range(CD - 1); cf_bit = $urandom_range(CWID - 1); cf_val = 1'($urandom_range(1));
            sf_addr = $urandom_range(SD - 1); sf_bit = $urandom_range(SWID - 1); sf_val = 1'($urandom_range(1));
            fault_run(ce, se, "R6 random");
        end

        // R9 pass-through again after tests
        fc_we_i = 1'b1; fc_waddr_i = 8'd200; fc_wdata_i = 18'h00F0F;
        @(negedge clk);
        fc_we_i = 1'b0; fc_raddr_i = 8'd200;
        @(negedge clk);
        chk("R9 coef after test", 32'(fc_rdata_o), 32'h00F0F);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule